// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer

This block holds outgoing data for one isochronous IN endpoint. Software loads packet bytes one at a time through a valid/ready byte port. It then closes each packet by writing that packet's byte count to a separate valid/ready length port. Because the length is written on its own, short packets and zero-length packets can be queued as easily as full ones. The byte store holds two maximum-size packets, and the length queue holds one entry per packet slot.

On the packet side, a one-cycle `tx_start` pulse (the host asked for data) opens the oldest queued packet. The block then streams it out over a valid/ready interface and marks the final byte with `tx_last`. An isochronous transfer cannot wait for late data. If the consumer is ready, the packet is still short of its length, and the store is empty, the packet ends at once as an underrun and the whole store is emptied.

A 4-bit control/status word reports progress:
- bit 0: room for a full packet (read-only).
- bit 1: packet finished (write-1-to-clear).
- bit 2: flush command (acts when 1 is written, always reads 0).
- bit 3: underrun (write-1-to-clear).

Back-pressure rules:
- A byte or length is taken on a clock edge where its valid and ready are both high.
- `tx_valid` stays high with `tx_data` and `tx_last` unchanged until `tx_ready` is seen.
- Holding `tx_ready` high is a demand for data. The producer must keep bytes ahead of it.

Top module: `isoc_in_txbuf`

## Requirements
- R1: After reset, `csr_rdata` reads 4'b0001, `tx_valid` is 0, and both `in_ready` and `len_ready` are 1.
- R2: Bit 0 of `csr_rdata` is 1 exactly when the free byte space (2*MAX_PKT minus stored bytes) is at least MAX_PKT.
- R3: Bytes are accepted on `in_valid && in_ready`. `in_ready` is 0 while 2*MAX_PKT bytes are stored. Bytes leave on `tx_data` in the order they were written.
- R4: A length is accepted on `len_valid && len_ready`. `len_ready` is 0 while PKT_SLOTS lengths are queued. Packets are sent in the order their lengths were written.
- R5: `tx_start` while no packet is open and a length is queued opens that packet. `tx_start` with no length queued has no effect. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold. `tx_last` is 1 on the final byte.
- R6: Bit 1 becomes 1 on the edge after the final byte is accepted. For a zero-length packet it becomes 1 on the edge after the packet opens.
- R7: Writing 1 to bit 1 or bit 3 clears only that bit. Writing 0 leaves it unchanged.
- R8: Writing 1 to bit 2 empties the byte store and the length queue in one cycle. It also abandons an open packet without setting bit 1, and it leaves bits 1 and 3 unchanged. Bit 2 always reads 0.
- R9: An underrun occurs when an open packet still owes bytes, the store is empty, and `tx_ready` is 1. The packet ends, bits 1 and 3 both become 1, and the byte store and length queue are emptied.
- R10: Bit 3 never rises unless bit 1 is also 1 in the same cycle, so bit 1 validates bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered by software |
| in_data | input | DATA_W | Byte value |
| in_ready | output | 1 | Byte store can take a byte |
| len_valid | input | 1 | Packet length offered (closes a packet) |
| len_data | input | LEN_W | Packet length in bytes, 0 to MAX_PKT |
| len_ready | output | 1 | Length queue can take an entry |
| tx_start | input | 1 | Host request pulse: open the next packet |
| tx_valid | output | 1 | Outgoing byte available |
| tx_data | output | DATA_W | Outgoing byte |
| tx_last | output | 1 | Outgoing byte is the packet's final byte |
| tx_ready | input | 1 | Packet side takes or demands a byte |
| csr_we | input | 1 | Control/status write strobe |
| csr_wdata | input | 4 | Control/status write value |
| csr_rdata | output | 4 | Control/status read value |

## Verification
The bench builds the block with MAX_PKT=4, PKT_SLOTS=2 and DATA_W=8. With these values the byte store is eight entries deep and the length queue is two deep. A few writes therefore reach the service-flag threshold, a full store and a full length queue. The same small size lets one table cover full, single-byte, zero-length and short-then-underrun packets, with back-to-back ordering, flush during transmission and independent flag clearing run as directed cases.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_SEND = 1'b1} seq_state_e;
  localparam int CSR_W   = 4;
  localparam int B_SVC   = 0;
  localparam int B_DONE  = 1;
  localparam int B_FLUSH = 2;
  localparam int B_UNDR  = 3;
endpackage

// File: rtl/txb_ring.sv
module txb_ring #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/txb_seq.sv
module txb_seq import txb_pkg::*; #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             lq_empty,
  input  logic [LEN_W-1:0] head_len,
  input  logic             fifo_empty,
  input  logic             tx_ready,
  output logic             lq_pop,
  output logic             fifo_pop,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             pkt_done,
  output logic             underrun
);
  seq_state_e       state;
  logic [LEN_W-1:0] rem;
  logic             busy, owed;

  assign busy     = (state == SEQ_SEND);
  assign owed     = (rem != '0);
  assign tx_valid = busy && owed && !fifo_empty;
  assign tx_last  = tx_valid && (rem == LEN_W'(1));
  assign fifo_pop = tx_valid && tx_ready;
  assign underrun = busy && owed && fifo_empty && tx_ready && !abort;
  assign pkt_done = busy && !abort && (!owed || (fifo_pop && tx_last) || underrun);
  assign lq_pop   = !busy && start && !lq_empty && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      rem   <= '0;
    end else if (abort || pkt_done) begin
      state <= SEQ_IDLE;
      rem   <= '0;
    end else if (lq_pop) begin
      state <= SEQ_SEND;
      rem   <= head_len;
    end else if (fifo_pop) begin
      rem   <= rem - LEN_W'(1);
    end
  end
endmodule

// File: rtl/txb_csr.sv
module txb_csr import txb_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             clr_done,
  input  logic             clr_undr,
  input  logic             svc,
  input  logic             done_evt,
  input  logic             undr_evt,
  output logic [CSR_W-1:0] rd_data
);
  logic done_q, undr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      undr_q <= 1'b0;
    end else begin
      if (done_evt)                 done_q <= 1'b1;
      else if (wr_en && clr_done)   done_q <= 1'b0;
      if (undr_evt)                 undr_q <= 1'b1;
      else if (wr_en && clr_undr)   undr_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_SVC]   = svc;
    rd_data[B_DONE]  = done_q;
    rd_data[B_UNDR]  = undr_q;
  end
endmodule

// File: rtl/isoc_in_txbuf.sv
module isoc_in_txbuf import txb_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int MAX_PKT   = 256,
  parameter int PKT_SLOTS = 2,
  localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              len_valid,
  input  logic [LEN_W-1:0]  len_data,
  output logic              len_ready,
  input  logic              tx_start,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata
);
  localparam int DEPTH  = MAX_PKT * PKT_SLOTS;
  localparam int BCNT_W = $clog2(DEPTH + 1);
  localparam int LCNT_W = $clog2(PKT_SLOTS + 1);

  logic              flush_cmd, underrun, pkt_done, clear_now;
  logic              fifo_pop, fifo_empty, lq_pop, lq_empty, svc;
  logic [BCNT_W-1:0] byte_cnt;
  logic [LCNT_W-1:0] lq_cnt;
  logic [LEN_W-1:0]  head_len;
  wire               unused_wbit = csr_wdata[B_SVC];

  assign flush_cmd = csr_we && csr_wdata[B_FLUSH];
  assign clear_now = flush_cmd || underrun;
  assign in_ready  = (byte_cnt != BCNT_W'(DEPTH)) && !clear_now;
  assign len_ready = (lq_cnt != LCNT_W'(PKT_SLOTS)) && !clear_now;
  assign svc       = (BCNT_W'(DEPTH) - byte_cnt) >= BCNT_W'(MAX_PKT);

  txb_ring #(.W(DATA_W), .DEPTH(DEPTH)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clear(clear_now),
    .push(in_valid), .push_data(in_data), .pop(fifo_pop),
    .head(tx_data), .count(byte_cnt), .empty(fifo_empty)
  );

  txb_ring #(.W(LEN_W), .DEPTH(PKT_SLOTS)) u_lens (
    .clk(clk), .rst_n(rst_n), .clear(clear_now),
    .push(len_valid), .push_data(len_data), .pop(lq_pop),
    .head(head_len), .count(lq_cnt), .empty(lq_empty)
  );

  txb_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(flush_cmd), .start(tx_start),
    .lq_empty(lq_empty), .head_len(head_len), .fifo_empty(fifo_empty),
    .tx_ready(tx_ready), .lq_pop(lq_pop), .fifo_pop(fifo_pop),
    .tx_valid(tx_valid), .tx_last(tx_last), .pkt_done(pkt_done),
    .underrun(underrun)
  );

  txb_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_we),
    .clr_done(csr_wdata[B_DONE]), .clr_undr(csr_wdata[B_UNDR]),
    .svc(svc), .done_evt(pkt_done), .undr_evt(underrun),
    .rd_data(csr_rdata)
  );
endmodule

// File: rtl/txb_chk.sv
module txb_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_last,
  input logic [DATA_W-1:0] tx_data,
  input logic              csr_we,
  input logic [3:0]        csr_wdata,
  input logic [3:0]        csr_rdata,
  input logic              pkt_done
);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_wdata[2]) |=> (csr_rdata[0] && !csr_rdata[2] && !tx_valid));

  // R6
  last_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && !(csr_we && csr_wdata[2])) |=> csr_rdata[1]);

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_wdata[1] && !pkt_done) |=> !csr_rdata[1]);

  // R10
  undr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rdata[3]) |-> csr_rdata[1]);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(csr_we && csr_wdata[2]))
      |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

bind isoc_in_txbuf txb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_last(tx_last), .tx_data(tx_data), .csr_we(csr_we),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .pkt_done(pkt_done)
);

// File: tb/test_isoc_in_txbuf.sv
module test_isoc_in_txbuf;
  localparam int DW    = 8;
  localparam int MAXP  = 4;
  localparam int SLOTS = 2;
  localparam int LW    = $clog2(MAXP + 1);
  localparam int DEPTH = MAXP * SLOTS;
  // vector fields: {bytes written[3:0], length[3:0], underrun expected}
  localparam int NV = 5;
  localparam logic [8:0] VEC [NV] = '{
    {4'd4, 4'd4, 1'b0},
    {4'd1, 4'd1, 1'b0},
    {4'd0, 4'd0, 1'b0},
    {4'd2, 4'd3, 1'b1},
    {4'd3, 4'd3, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, len_valid = 0, tx_start = 0, tx_ready = 1, csr_we = 0;
  logic [DW-1:0] in_data = '0;
  logic [LW-1:0] len_data = '0;
  logic [3:0] csr_wdata = '0;
  logic in_ready, len_ready, tx_valid, tx_last;
  logic [DW-1:0] tx_data;
  logic [3:0] csr_rdata;

  int total = 0, bad = 0, rx_n = 0;
  logic [DW-1:0] rx_buf [16];
  logic rx_lst [16];
  bit finished = 0;

  always #4 clk = ~clk;

  isoc_in_txbuf #(.DATA_W(DW), .MAX_PKT(MAXP), .PKT_SLOTS(SLOTS)) i_isoc_in_txbuf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .len_valid(len_valid), .len_data(len_data),
    .len_ready(len_ready), .tx_start(tx_start), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready && rx_n < 16) begin
      rx_buf[rx_n] = tx_data;
      rx_lst[rx_n] = tx_last;
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [DW-1:0] d);
    @(negedge clk); in_valid = 1; in_data = d; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic push_len(input int l);
    @(negedge clk); len_valid = 1; len_data = LW'(l); #1;
    while (!len_ready) begin @(negedge clk); #1; end
    @(negedge clk); len_valid = 0;
  endtask

  task automatic csr_wr(input logic [3:0] v);
    @(negedge clk); csr_we = 1; csr_wdata = v;
    @(negedge clk); csr_we = 0; csr_wdata = '0;
  endtask

  task automatic start_tx();
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20 && !csr_rdata[1]; i++) @(negedge clk);
    #3;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(csr_rdata == 4'b0001, "R1 csr", csr_rdata, 1);
    chk(!tx_valid && in_ready && len_ready, "R1 ready/valid",
        {tx_valid, in_ready, len_ready}, 3);

    // table of packets
    for (int v = 0; v < NV; v++) begin
      int nb, ln, ex_n;
      bit un;
      nb = int'(VEC[v][8:5]); ln = int'(VEC[v][4:1]); un = VEC[v][0];
      ex_n = (nb < ln) ? nb : ln;
      tx_ready = 1;
      for (int k = 0; k < nb; k++) push_byte(DW'(v * 16 + k + 1));
      push_len(ln);
      rx_n = 0;
      start_tx();
      wait_done();
      chk(rx_n == ex_n, "R3 byte count", rx_n, ex_n);
      for (int k = 0; k < ex_n; k++) begin
        chk(rx_buf[k] == DW'(v * 16 + k + 1), "R3 byte order", rx_buf[k], v * 16 + k + 1);
        chk(rx_lst[k] == (!un && k == ex_n - 1), "R5 last flag", rx_lst[k], !un && k == ex_n - 1);
      end
      // R6 done set; R9/R10 underrun with done
      chk(csr_rdata == {un, 3'b011}, un ? "R9 underrun flags" : "R6 done flag",
          csr_rdata, {un, 3'b011});
      csr_wr(4'b1010);
      #1;
      chk(csr_rdata == 4'b0001, "R7 clear both", csr_rdata, 1);
    end

    // R4 two queued packets go out in order
    push_byte(8'hA1); push_byte(8'hA2); push_len(2);
    push_byte(8'hB1); push_len(1);
    #1;
    chk(!len_ready, "R4 queue full", len_ready, 0);
    rx_n = 0;
    start_tx(); wait_done(); csr_wr(4'b0010);
    start_tx(); wait_done();
    chk(rx_n == 3 && rx_buf[0] == 8'hA1 && rx_buf[1] == 8'hA2 && rx_buf[2] == 8'hB1,
        "R4 packet order", rx_buf[2], 8'hB1);
    csr_wr(4'b0010);

    // R2 service threshold, R3 full store
    for (int k = 0; k < MAXP; k++) push_byte(DW'(k));
    #1;
    chk(csr_rdata[0] == 1'b1, "R2 svc at half", csr_rdata[0], 1);
    push_byte(8'h77);
    #1;
    chk(csr_rdata[0] == 1'b0, "R2 svc below", csr_rdata[0], 0);
    for (int k = MAXP + 1; k < DEPTH; k++) push_byte(DW'(k));
    #1;
    chk(!in_ready, "R3 store full", in_ready, 0);

    // R8 flush keeps flags: make done set by a zero-length packet
    push_len(0); start_tx(); wait_done();
    csr_wr(4'b0100);
    #1;
    chk(csr_rdata == 4'b0011, "R8 flush keeps flags", csr_rdata, 3);
    chk(in_ready && len_ready, "R8 flush empties", {in_ready, len_ready}, 3);
    // R5 start with nothing queued is ignored
    csr_wr(4'b0010);
    start_tx();
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_valid && csr_rdata == 4'b0001, "R5 start ignored", csr_rdata, 1);

    // R5 back-pressure hold
    tx_ready = 0;
    push_byte(8'h55); push_byte(8'h66); push_len(2);
    rx_n = 0;
    start_tx();
    repeat (3) @(negedge clk);
    #1;
    chk(tx_valid && tx_data == 8'h55 && !tx_last, "R5 hold", tx_data, 8'h55);
    chk(rx_n == 0, "R5 nothing taken", rx_n, 0);
    tx_ready = 1;
    wait_done();
    chk(rx_n == 2 && rx_buf[1] == 8'h66 && rx_lst[1], "R5 after hold", rx_buf[1], 8'h66);
    csr_wr(4'b0010);

    // R8 flush aborts an open packet without done
    tx_ready = 0;
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33); push_len(3);
    start_tx();
    repeat (2) @(negedge clk);
    csr_wr(4'b0100);
    repeat (2) @(negedge clk);
    #1;
    chk(!tx_valid && csr_rdata == 4'b0001, "R8 abort no done", csr_rdata, 1);

    // R9 underrun clears length queue; R7 independent clears
    tx_ready = 1;
    push_byte(8'h99); push_len(2); push_len(1);
    start_tx(); wait_done();
    chk(csr_rdata == 4'b1011, "R9 underrun", csr_rdata, 4'hB);
    csr_wr(4'b0010);
    #1;
    chk(csr_rdata == 4'b1001, "R7 clear done only", csr_rdata, 9);
    csr_wr(4'b0000);
    #1;
    chk(csr_rdata == 4'b1001, "R7 zero write", csr_rdata, 9);
    csr_wr(4'b1000);
    #1;
    chk(csr_rdata == 4'b0001, "R7 clear underrun", csr_rdata, 1);
    start_tx();
    repeat (4) @(negedge clk);
    #1;
    chk(csr_rdata == 4'b0001 && !tx_valid, "R9 queue emptied", csr_rdata, 1);

    finish_run();
  end
endmodule